// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose pins behind a small register bus. Each pin has three registers that set how it drives and what it reads back: an output value, a drive enable, and a synchronised copy of the pin input. Each pin also has an interrupt path. A pin can be attached to the interrupt logic. Its trigger can be a rising edge, a falling edge, a high level or a low level. When the trigger fires, the pin sets a sticky status bit, and that bit can raise the single interrupt line of the bank only if the pin is enabled.

Every writable register has three write addresses. The base address loads the whole word. Base plus 4 ORs the data into the register. Base plus 8 clears the bits written as 1. Software can therefore change a few pins without a read-modify-write. The status register changes only through its clear address. The bank index parameter moves the whole register set by 0x10 per bank, so several banks can share one address space.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_o` are zero, `irq` is low and `bus_rvalid` is low.
- R2: A write to page base + 0x0 loads the register. A write to base + 0x4 sets only the bits written as 1. A write to base + 0x8 clears only the bits written as 1. This holds for the output data, drive enable, pin select, interrupt enable, trigger level and trigger polarity registers.
- R3: Register pages sit at 0x700 (output data), 0x900 (input), 0xB00 (drive enable), 0x1000 (pin select), 0x1100 (interrupt enable), 0x1200 (level), 0x1300 (polarity) and 0x1400 (status), each plus 0x10 × `BANK_IDX`. A read at base, base + 4 or base + 8 returns the register value.
- R4: `pad_oe` equals the drive enable register. `pad_o[i]` equals output data bit i when `pad_oe[i]` is 1 and is 0 otherwise.
- R5: The input register returns `pin_in` after a two-flop synchroniser. Writes to any of its addresses have no effect.
- R6: Per pin, the trigger code is {polarity, level}: 0 falling edge, 1 low level, 2 rising edge, 3 high level. Edges are judged between consecutive synchronised samples.
- R7: A pin whose select bit is 0 never sets its status bit.
- R8: Status bits are sticky. Writes to the status base and set addresses have no effect. A write to the status clear address clears the bits written as 1. A trigger in the same cycle as the clear keeps its bit set.
- R9: A level-triggered pin that is still at its active level has its status set again after a clear, so a later read returns 1.
- R10: Status bits latch whether or not the pin is enabled. `irq` is high exactly when (status AND interrupt enable) is non-zero, and it rises in the third clock after a qualifying input change.
- R11: A read returns data with `bus_rvalid` high in the cycle after the request. Any address outside the mapped pages and views, including the +0xC offset, reads zero and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pin_in | input | PINS | Asynchronous pin inputs |
| pad_o | output | PINS | Pad output value |
| pad_oe | output | PINS | Pad drive enable, 0 = released |
| irq | output | 1 | Combined bank interrupt |

## Verification
A wrong trigger decode or a stale previous sample shows up in the status read that follows a pin change, about five cycles later. A status bit that leaks or sticks shows up at once on `irq` for enabled pins, and in the next status read for pins that are not enabled. Errors in the alias logic change the value read back on the very next bus read. Pad errors show up on `pad_o` and `pad_oe` one cycle after the write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int NREG     = 8;
   localparam int IDX_DOUT = 0;
   localparam int IDX_DIN  = 1;
   localparam int IDX_DOE  = 2;
   localparam int IDX_SEL  = 3;
   localparam int IDX_IEN  = 4;
   localparam int IDX_LEV  = 5;
   localparam int IDX_POL  = 6;
   localparam int IDX_STAT = 7;

   typedef enum logic [1:0] {
      WV_LOAD = 2'd0,
      WV_SET  = 2'd1,
      WV_CLR  = 2'd2,
      WV_NONE = 2'd3
   } wview_e;

   // page number (address bits above the 16-byte slot) of each register
   function automatic int unsigned reg_page(input int unsigned idx);
      case (idx)
         0:       reg_page = 'h070;
         1:       reg_page = 'h090;
         2:       reg_page = 'h0B0;
         3:       reg_page = 'h100;
         4:       reg_page = 'h110;
         5:       reg_page = 'h120;
         6:       reg_page = 'h130;
         default: reg_page = 'h140;
      endcase
   endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_bank_pkg::*;
#(
   parameter int AW       = 13,
   parameter int BANK_IDX = 0
) (
   input  logic [AW-1:0]   addr,
   output logic [NREG-1:0] hit,
   output wview_e          view
);
   localparam int PW = AW - 4;

   if (PW < 9) begin : g_aw_bad
      $error("gpio_addr_dec: AW too small for the register pages");
   end
   if ((reg_page(NREG-1) + BANK_IDX) >= (1 << PW)) begin : g_bank_bad
      $error("gpio_addr_dec: BANK_IDX pushes pages beyond AW");
   end

   always_comb begin
      case (addr[3:0])
         4'h0:    view = WV_LOAD;
         4'h4:    view = WV_SET;
         4'h8:    view = WV_CLR;
         default: view = WV_NONE;
      endcase
   end

   for (genvar k = 0; k < NREG; k++) begin : g_hit
      localparam logic [PW-1:0] PAGE = PW'(reg_page(k) + BANK_IDX);
      assign hit[k] = (addr[AW-1:4] == PAGE) && (view != WV_NONE);
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_stage_bad
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
   import gpio_bank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  wview_e       view,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we) begin
         case (view)
            WV_LOAD: q <= wdata;
            WV_SET:  q <= q | wdata;
            WV_CLR:  q <= q & ~wdata;
            default: q <= q;
         endcase
      end
   end

   // R2
   cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> $past(we));

endmodule

// File: rtl/gpio_event_status.sv
module gpio_event_status #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] sel,
   input  logic [W-1:0] lev,
   input  logic [W-1:0] pol,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] stat
);
   logic [W-1:0] prev;
   logic [W-1:0] hit;
   logic [W-1:0] lvl_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= smp;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic edge_on;
      assign lvl_on[i] = ~(smp[i] ^ pol[i]);
      assign edge_on   = pol[i] ? (smp[i] & ~prev[i]) : (~smp[i] & prev[i]);
      assign hit[i]    = sel[i] & (lev[i] ? lvl_on[i] : edge_on);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~(clr_we ? clr_mask : '0)) | hit;
   end

   // R7
   sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat & ~$past(stat) & ~$past(sel)) == '0));

   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(stat) & ~stat) != '0) |-> $past(clr_we));

   // R9
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(sel & lev & lvl_on) & ~stat) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int PINS        = 32,
   parameter int AW          = 13,
   parameter int BANK_IDX    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [PINS-1:0] bus_wdata,
   output logic [PINS-1:0] bus_rdata,
   output logic            bus_rvalid,
   input  logic [PINS-1:0] pin_in,
   output logic [PINS-1:0] pad_o,
   output logic [PINS-1:0] pad_oe,
   output logic            irq
);
   if (PINS < 1 || PINS > 32) begin : g_pins_bad
      $error("gpio_bank: PINS must be 1..32");
   end

   logic [NREG-1:0]            hit;
   wview_e                     view;
   logic [NREG-1:0][PINS-1:0]  rq;
   logic [PINS-1:0]            smp;
   logic [PINS-1:0]            stat;
   logic [PINS-1:0]            rmux;
   logic                       wr_go;
   logic                       stat_clr;

   gpio_addr_dec #(.AW(AW), .BANK_IDX(BANK_IDX)) u_dec (
      .addr (bus_addr),
      .hit  (hit),
      .view (view)
   );

   gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (smp)
   );

   assign wr_go = bus_sel & bus_wr;

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      if (k == IDX_DIN) begin : g_in
         assign rq[k] = smp;
      end else if (k == IDX_STAT) begin : g_st
         assign rq[k] = stat;
      end else begin : g_cfg
         gpio_cfg_reg #(.W(PINS)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_go & hit[k]),
            .view  (view),
            .wdata (bus_wdata),
            .q     (rq[k])
         );
      end
   end

   assign stat_clr = wr_go & hit[IDX_STAT] & (view == WV_CLR);

   gpio_event_status #(.W(PINS)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .sel      (rq[IDX_SEL]),
      .lev      (rq[IDX_LEV]),
      .pol      (rq[IDX_POL]),
      .clr_we   (stat_clr),
      .clr_mask (bus_wdata),
      .stat     (stat)
   );

   always_comb begin
      rmux = '0;
      for (int k = 0; k < NREG; k++) if (hit[k]) rmux = rq[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_sel & ~bus_wr;
         if (bus_sel & ~bus_wr) bus_rdata <= rmux;
      end
   end

   assign pad_oe = rq[IDX_DOE];
   assign pad_o  = rq[IDX_DOUT] & rq[IDX_DOE];
   assign irq    = |(stat & rq[IDX_IEN]);

   // R10
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_go & (hit[IDX_STAT] | hit[IDX_IEN])));

   // R11
   rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_sel & ~bus_wr));

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
   localparam logic [12:0] A_DOUT = 13'h0710;
   localparam logic [12:0] A_DIN  = 13'h0910;
   localparam logic [12:0] A_DOE  = 13'h0B10;
   localparam logic [12:0] A_SEL  = 13'h1010;
   localparam logic [12:0] A_IEN  = 13'h1110;
   localparam logic [12:0] A_LEV  = 13'h1210;
   localparam logic [12:0] A_POL  = 13'h1310;
   localparam logic [12:0] A_ST   = 13'h1410;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [31:0] pin_in = '0;
   logic [31:0] pad_o, pad_oe;
   logic        irq;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_bank #(.PINS(32), .AW(13), .BANK_IDX(1), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pad_o(pad_o),
      .pad_oe(pad_oe), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] expect_stat(input int mode, input logic [31:0] a, input logic [31:0] b);
      case (mode)
         0:       return a & ~b;
         1:       return ~a | ~b;
         2:       return b & ~a;
         default: return a | b;
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      logic [12:0] cfg [6];
      logic [31:0] pa [4];
      logic [31:0] pb [4];
      cfg = '{A_DOUT, A_DOE, A_SEL, A_IEN, A_LEV, A_POL};
      pa  = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hF0F0_3C3C, 32'h1234_5678};
      pb  = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFF00_C3C3, 32'h8765_4321};

      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 pad_oe", pad_oe, 0);
      check("R1 pad_o", pad_o, 0);
      check("R1 irq", {31'd0, irq}, 0);
      check("R1 rvalid", {31'd0, bus_rvalid}, 0);
      for (int k = 0; k < 6; k++) begin
         rd(cfg[k], v); check("R1 cfg reg", v, 0);
      end
      rd(A_ST, v); check("R1 status", v, 0);

      // R2 and R3 alias writes and read views on every writable register
      for (int k = 0; k < 6; k++) begin
         wr(cfg[k], 32'hA5A5_0F0F);
         rd(cfg[k], v);         check("R2 load", v, 32'hA5A5_0F0F);
         wr(cfg[k] + 13'h4, 32'h0000_F000);
         rd(cfg[k] + 13'h4, v); check("R2 set", v, 32'hA5A5_FF0F);
         wr(cfg[k] + 13'h8, 32'hA000_0001);
         rd(cfg[k] + 13'h8, v); check("R3 clr view read", v, 32'h05A5_FF0E);
         wr(cfg[k], 32'h0);
      end

      // R11 unmapped view, other bank, write ignored
      wr(A_DOUT + 13'hC, 32'hFFFF_FFFF);
      rd(A_DOUT, v);          check("R11 +C write ignored", v, 0);
      rd(A_DOUT + 13'hC, v);  check("R11 +C read zero", v, 0);
      wr(A_DOUT - 13'h10, 32'hFFFF_FFFF);
      rd(A_DOUT, v);          check("R11 other bank ignored", v, 0);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_DOE;
      @(negedge clk);
      bus_sel = 1'b0;
      check("R11 rvalid after read", {31'd0, bus_rvalid}, 1);
      @(negedge clk);
      check("R11 rvalid drops", {31'd0, bus_rvalid}, 0);

      // R4 pads
      wr(A_DOE, 32'hFFFF_0000);
      wr(A_DOUT, 32'h1234_5678);
      check("R4 pad_oe", pad_oe, 32'hFFFF_0000);
      check("R4 pad_o", pad_o, 32'h1234_0000);
      wr(A_DOE + 13'h8, 32'hFFFF_FFFF);
      check("R4 released", pad_o, 0);

      // R5 input path
      pin_in = 32'hDEAD_BEEF;
      idle(3);
      rd(A_DIN, v); check("R5 input read", v, 32'hDEAD_BEEF);
      wr(A_DIN, 32'h0);
      wr(A_DIN + 13'h8, 32'hFFFF_FFFF);
      rd(A_DIN, v); check("R5 input write ignored", v, 32'hDEAD_BEEF);

      // R6 trigger sweep: all modes over several pattern pairs
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 4; p++) begin
            wr(A_SEL, 32'h0);
            pin_in = pa[p];
            idle(4);
            wr(A_LEV, (m % 2 == 1) ? 32'hFFFF_FFFF : 32'h0);
            wr(A_POL, (m >= 2) ? 32'hFFFF_FFFF : 32'h0);
            wr(A_ST + 13'h8, 32'hFFFF_FFFF);
            wr(A_SEL, 32'hFFFF_FFFF);
            idle(2);
            pin_in = pb[p];
            idle(5);
            rd(A_ST, v);
            check($sformatf("R6 mode %0d pattern %0d", m, p), v, expect_stat(m, pa[p], pb[p]));
         end
      end

      // R7 select gating: rising edges, only low half selected
      wr(A_SEL, 32'h0);
      pin_in = 32'h0;
      wr(A_LEV, 32'h0);
      wr(A_POL, 32'hFFFF_FFFF);
      idle(4);
      wr(A_ST + 13'h8, 32'hFFFF_FFFF);
      wr(A_SEL, 32'h0000_FFFF);
      pin_in = 32'hFFFF_FFFF;
      idle(5);
      rd(A_ST, v); check("R7 unselected pins", v, 32'h0000_FFFF);

      // R8 sticky, base and set writes ignored, partial clear
      pin_in = 32'h0;
      idle(5);
      rd(A_ST, v); check("R8 sticky after pin drop", v, 32'h0000_FFFF);
      wr(A_ST, 32'h0);
      wr(A_ST + 13'h4, 32'hFFFF_FFFF);
      rd(A_ST, v); check("R8 base and set ignored", v, 32'h0000_FFFF);
      wr(A_ST + 13'h8, 32'h0000_00FF);
      rd(A_ST, v); check("R8 partial clear", v, 32'h0000_FF00);

      // R10 enable gating of irq
      wr(A_IEN, 32'hFFFF_0000);
      check("R10 irq disabled pins", {31'd0, irq}, 0);
      wr(A_IEN, 32'h0000_0100);
      check("R10 irq enabled pin", {31'd0, irq}, 1);
      wr(A_ST + 13'h8, 32'h0000_0100);
      check("R10 irq after clear", {31'd0, irq}, 0);

      // R10 irq timing: rising edge on pin 5
      wr(A_ST + 13'h8, 32'hFFFF_FFFF);
      wr(A_SEL, 32'h0000_0020);
      wr(A_IEN, 32'h0000_0020);
      idle(3);
      pin_in = 32'h0000_0020;
      @(negedge clk); check("R10 irq clock 1", {31'd0, irq}, 0);
      @(negedge clk); check("R10 irq clock 2", {31'd0, irq}, 0);
      @(negedge clk); check("R10 irq clock 3", {31'd0, irq}, 1);

      // R9 level high re-arms after clear
      wr(A_IEN, 32'h0);
      wr(A_SEL, 32'h0000_0001);
      wr(A_LEV, 32'h0000_0001);
      pin_in = 32'h0000_0001;
      idle(4);
      wr(A_ST + 13'h8, 32'hFFFF_FFFF);
      idle(1);
      rd(A_ST, v); check("R9 level re-set", v, 32'h0000_0001);
      pin_in = 32'h0;
      idle(4);
      wr(A_ST + 13'h8, 32'hFFFF_FFFF);
      rd(A_ST, v); check("R9 inactive level clears", v, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule